// File: doc/BRIEF.md
# Boot Hold-Off Sequencer

This block sits beside a small processor core and decides, as reset ends, how the core's program memory gets filled before any instruction runs. It reads a three-pin boot code once, at the first clock edge after reset is released, and keeps that choice for the whole session. In byte-DMA boot it asks the DMA engine for a fixed first block of words and counts the engine's per-word completion pulses. In host-port boot it watches the host's writes into program memory. The core is released only when the chosen load has finished.

The only outputs to the core are a registered run enable and a start program counter, which is always zero. Boot codes that select neither loader let the core run straight away. The DMA datapath, the memories and the core live outside the block.

Top module: `bootSeqTop`

## Requirements
- R1: While rstN is low, runEn and dmaReq are 0 and startPc is 0.
- R2: The boot code {modePins[2], modePins[1], modePins[0]} is captured at the first rising clock edge with rstN high. Later changes on modePins have no effect until the next reset.
- R3: Code 3'b101 selects host-port boot. In this mode dmaReq stays 0 and dmaWordDone pulses are ignored.
- R4: Code 3'b000 selects byte-DMA boot. dmaReq is 1 from the capture edge until the core is released, and dmaWordCnt always equals BOOT_WORDS (32).
- R5: In byte-DMA boot, runEn goes to 1 after the clock edge at which the BOOT_WORDS-th dmaWordDone pulse is sampled, and not earlier. dmaReq goes to 0 at that same edge.
- R6: In host-port boot, runEn goes to 1 after the clock edge at which hostWrStb is sampled high with hostWrAddr equal to 0.
- R7: In host-port boot, any number of host writes to nonzero addresses leave runEn at 0. In byte-DMA boot, host writes to any address, including address 0, leave runEn at 0.
- R8: Any other code sets runEn to 1 at the capture edge.
- R9: Once runEn is 1 it stays 1 until reset, and startPc stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modePins | input | 3 | Boot code pins {C,B,A} |
| dmaReq | output | 1 | Request for the first byte-DMA block |
| dmaWordCnt | output | CNT_W (6) | Number of words in the first DMA block |
| dmaWordDone | input | 1 | One-cycle pulse for each completed DMA word |
| hostWrStb | input | 1 | Host write strobe into program memory |
| hostWrAddr | input | ADDR_W (14) | Program memory address of the host write |
| runEn | output | 1 | Core run enable |
| startPc | output | PC_W (14) | Program counter to start from |

## Verification
The assertions take for granted that dmaWordDone only pulses while the DMA request is outstanding or is ignored, that hostWrStb is a single-cycle qualifier with a stable address, and that reset is held for at least one edge. The bench drives every input at the falling edge, so each strobe lasts exactly one sampled cycle. It picks random boot codes, random gaps between DMA pulses and random nonzero host addresses, and it changes modePins after capture. Directed sessions cover the code boundaries and a host write to address 0 during DMA boot.

// File: rtl/bootSeqPkg.sv
package bootSeqPkg;
  typedef enum logic [1:0] {MODE_NONE, MODE_DMA, MODE_HOST} bootMode_e;
  typedef enum logic [1:0] {ST_SAMPLE, ST_HOLD, ST_RUN} seqState_e;

  typedef struct packed {
    logic sampleMode;
    logic cntInc;
    logic release_;
  } seqStrobes_t;

  function automatic bootMode_e decodeMode(input logic [2:0] pins);
    case (pins)
      3'b101:  return MODE_HOST;
      3'b000:  return MODE_DMA;
      default: return MODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/bootSeqPath.sv
module bootSeqPath
  import bootSeqPkg::*;
#(
  parameter int BOOT_WORDS = 32,
  parameter int CNT_W      = $clog2(BOOT_WORDS + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  modePins,
  input  seqStrobes_t strobes,
  output bootMode_e   modeQ,
  output logic        cntLast,
  output logic        runEnQ
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BOOT_WORDS - 1);

  logic [CNT_W-1:0] wordCntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_NONE;
    end else if (strobes.sampleMode) begin
      modeQ <= decodeMode(modePins);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCntQ <= '0;
    end else if (strobes.cntInc && !cntLast) begin
      wordCntQ <= wordCntQ + 1'b1;
    end
  end

  assign cntLast = (wordCntQ == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEnQ <= 1'b0;
    end else if (strobes.release_) begin
      runEnQ <= 1'b1;
    end
  end
endmodule

// File: rtl/bootSeqCtrl.sv
module bootSeqCtrl
  import bootSeqPkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modePins,
  input  bootMode_e         modeQ,
  input  logic              cntLast,
  input  logic              dmaWordDone,
  input  logic              hostWrStb,
  input  logic [ADDR_W-1:0] hostWrAddr,
  output seqStrobes_t       strobes,
  output logic              dmaReq
);
  seqState_e stateQ, stateD;
  logic      hostZeroWr;
  logic      dmaFinal;

  assign hostZeroWr = hostWrStb && (hostWrAddr == '0);
  assign dmaFinal   = dmaWordDone && cntLast;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    case (stateQ)
      ST_SAMPLE: begin
        strobes.sampleMode = 1'b1;
        if (decodeMode(modePins) == MODE_NONE) begin
          strobes.release_ = 1'b1;
          stateD           = ST_RUN;
        end else begin
          stateD = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (modeQ == MODE_DMA) begin
          strobes.cntInc = dmaWordDone;
          if (dmaFinal) begin
            strobes.release_ = 1'b1;
            stateD           = ST_RUN;
          end
        end else if (modeQ == MODE_HOST) begin
          if (hostZeroWr) begin
            strobes.release_ = 1'b1;
            stateD           = ST_RUN;
          end
        end else begin
          strobes.release_ = 1'b1;
          stateD           = ST_RUN;
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_SAMPLE;
    else       stateQ <= stateD;
  end

  assign dmaReq = (stateQ == ST_HOLD) && (modeQ == MODE_DMA);
endmodule

// File: rtl/bootSeqTop.sv
module bootSeqTop
  import bootSeqPkg::*;
#(
  parameter int BOOT_WORDS = 32,
  parameter int ADDR_W     = 14,
  parameter int PC_W       = 14,
  parameter int CNT_W      = $clog2(BOOT_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modePins,
  output logic              dmaReq,
  output logic [CNT_W-1:0]  dmaWordCnt,
  input  logic              dmaWordDone,
  input  logic              hostWrStb,
  input  logic [ADDR_W-1:0] hostWrAddr,
  output logic              runEn,
  output logic [PC_W-1:0]   startPc
);
  seqStrobes_t strobes;
  bootMode_e   modeQ;
  logic        cntLast;

  bootSeqCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .modePins(modePins), .modeQ(modeQ),
    .cntLast(cntLast), .dmaWordDone(dmaWordDone), .hostWrStb(hostWrStb),
    .hostWrAddr(hostWrAddr), .strobes(strobes), .dmaReq(dmaReq)
  );

  bootSeqPath #(.BOOT_WORDS(BOOT_WORDS), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .modePins(modePins), .strobes(strobes),
    .modeQ(modeQ), .cntLast(cntLast), .runEnQ(runEn)
  );

  assign dmaWordCnt = CNT_W'(BOOT_WORDS);
  assign startPc    = '0;
endmodule

// File: rtl/bootSeqChk.sv
module bootSeqChk
  import bootSeqPkg::*;
#(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input bootMode_e         modeQ,
  input logic              dmaReq,
  input logic              dmaWordDone,
  input logic              hostWrStb,
  input logic [ADDR_W-1:0] hostWrAddr,
  input logic              runEn
);
  // R9
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> runEn);

  // R5
  req_run_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dmaReq && runEn));

  // R3
  host_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_HOST) |-> !dmaReq);

  // R7
  host_nonzero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_HOST && !runEn && hostWrStb && hostWrAddr != '0) |=> !runEn);

  // R6
  host_release_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_HOST && $rose(runEn)) |-> $past(hostWrStb && hostWrAddr == '0));

  // R5
  dma_release_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_DMA && $rose(runEn)) |-> $past(dmaWordDone && dmaReq));
endmodule

bind bootSeqTop bootSeqChk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .modeQ(modeQ), .dmaReq(dmaReq),
  .dmaWordDone(dmaWordDone), .hostWrStb(hostWrStb),
  .hostWrAddr(hostWrAddr), .runEn(runEn)
);

// File: tb/tb_bootSeqTop.sv
`timescale 1ns/1ps
module tb_bootSeqTop;
  localparam int BOOT_WORDS = 32;
  localparam int ADDR_W = 14;
  localparam int PC_W = 14;
  localparam int CNT_W = $clog2(BOOT_WORDS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modePins = '0;
  logic dmaReq;
  logic [CNT_W-1:0] dmaWordCnt;
  logic dmaWordDone = 1'b0;
  logic hostWrStb = 1'b0;
  logic [ADDR_W-1:0] hostWrAddr = '0;
  logic runEn;
  logic [PC_W-1:0] startPc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bootSeqTop #(.BOOT_WORDS(BOOT_WORDS), .ADDR_W(ADDR_W), .PC_W(PC_W)) dut (
    .clk(clk), .rstN(rstN), .modePins(modePins), .dmaReq(dmaReq),
    .dmaWordCnt(dmaWordCnt), .dmaWordDone(dmaWordDone), .hostWrStb(hostWrStb),
    .hostWrAddr(hostWrAddr), .runEn(runEn), .startPc(startPc)
  );

  // 0 = none, 1 = byte DMA, 2 = host
  function automatic int expMode(input logic [2:0] p);
    if (p == 3'b101) return 2;
    if (p == 3'b000) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dmaWordDone = 1'b0; hostWrStb = 1'b0;
      tick();
    end
  endtask

  task automatic pulseDone();
    @(negedge clk); dmaWordDone = 1'b1; hostWrStb = 1'b0;
    tick();
    @(negedge clk); dmaWordDone = 1'b0;
  endtask

  task automatic hostWrite(input logic [ADDR_W-1:0] a);
    @(negedge clk); hostWrStb = 1'b1; hostWrAddr = a; dmaWordDone = 1'b0;
    tick();
    @(negedge clk); hostWrStb = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] randNonZero();
    logic [ADDR_W-1:0] a;
    a = ADDR_W'($urandom);
    if (a == '0) a = 1;
    return a;
  endfunction

  task automatic session(input logic [2:0] code, input bit hostZeroInDma);
    int m;
    m = expMode(code);
    @(negedge clk);
    rstN = 1'b0; modePins = code; dmaWordDone = 1'b0; hostWrStb = 1'b0;
    #1;
    check("R1 runEn in reset", runEn, 0);
    check("R1 dmaReq in reset", dmaReq, 0);
    check("R1 startPc in reset", int'(startPc), 0);
    tick();
    @(negedge clk); rstN = 1'b1;
    tick();  // capture edge
    @(negedge clk); modePins = ~code;  // R2: later pin changes ignored
    check("R8/R2 runEn after capture", runEn, (m == 0) ? 1 : 0);
    check("R4/R3 dmaReq after capture", dmaReq, (m == 1) ? 1 : 0);
    check("R4 dmaWordCnt", int'(dmaWordCnt), BOOT_WORDS);
    if (m == 1) begin
      if (hostZeroInDma) begin
        hostWrite('0);
        #1 check("R7 host addr 0 in DMA boot", runEn, 0);
      end
      for (int k = 1; k <= BOOT_WORDS; k++) begin
        idle($urandom_range(0, 2));
        if ($urandom_range(0, 3) == 0) begin
          hostWrite(randNonZero());
          #1 check("R7 host write in DMA boot", runEn, 0);
        end
        pulseDone();
        #1;
        if (k == BOOT_WORDS || k == BOOT_WORDS - 1) begin
          check("R5 runEn at word count", runEn, (k == BOOT_WORDS) ? 1 : 0);
          check("R5 dmaReq at word count", dmaReq, (k == BOOT_WORDS) ? 0 : 1);
        end else if (runEn !== 1'b0) begin
          check("R5 early release", runEn, 0);
        end
      end
    end else if (m == 2) begin
      int n;
      n = $urandom_range(1, 6);
      for (int i = 0; i < n; i++) begin
        hostWrite(randNonZero());
        #1 check("R7 nonzero host write", runEn, 0);
        pulseDone();
        #1 check("R3 DMA pulse in host boot", runEn, 0);
        check("R3 dmaReq in host boot", dmaReq, 0);
      end
      hostWrite('0);
      #1 check("R6 host write to 0", runEn, 1);
    end
    idle(3);
    check("R9 runEn sticky", runEn, 1);
    check("R9 startPc", int'(startPc), 0);
    pulseDone();
    hostWrite('0);
    #1 check("R9 runEn after late strobes", runEn, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_b007));
    repeat (2) tick();
    // directed corner cases
    session(3'b000, 1'b1);
    session(3'b101, 1'b0);
    session(3'b100, 1'b0);
    session(3'b001, 1'b0);
    session(3'b111, 1'b0);
    // random sessions
    for (int s = 0; s < 12; s++) begin
      session(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule